// File: doc/BRIEF.md
# Text Row Scan and Refresh Address Counter

This block produces the vertical half of a character-display timing chain. A 10-bit scan-line counter steps once per end-of-line pulse and wraps after a programmed total. From that count the block derives vertical display enable, vertical blanking and vertical retrace. A row-scan counter tracks which scan line of a character row is being drawn. A refresh address counter walks video memory one location per displayed character clock. The block also raises cursor and underline flags that a downstream attribute stage can use.

All settings arrive as plain input buses that are expected to hold still while the block runs. Smooth vertical scrolling comes from a preset row scan that is loaded at the top of each frame. A split screen comes from a line-compare value: when the line counter reaches it, the address and row state are cleared. Optional line doubling halves the rate of the row-scan clock. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `row_scan_addr_gen`

## Requirements
- R1: On each `line_end` pulse, `line_cnt` advances by one. When `line_cnt` equals `vtotal`, the next pulse takes it to 0 instead. Without a pulse, `line_cnt` holds its value. `vde` is high exactly while `line_cnt <= vdisp_end`.
- R2: `vretrace` rises on the pulse that moves `line_cnt` to `vret_start`. Once high, it falls on the pulse that moves `line_cnt` to a value whose bits [3:0] equal `vret_end`.
- R3: `vblank` rises on the pulse that moves `line_cnt` to `vblank_start`. Once high, it falls on the pulse that moves `line_cnt` to a value whose bits [7:0] equal `vblank_end`.
- R4: The pulse that wraps `line_cnt` to 0 loads `row_scan` with `preset_row`. Each later row-scan tick increments `row_scan`. A tick taken while `row_scan == max_scan` sets it to 0, not back to the preset.
- R5: With `line_dbl` = 0, every `line_end` is a row-scan tick. With `line_dbl` = 1, only every second `line_end` is a tick, counting from the frame top or from a line-compare hit. The first pulse after either of those is not a tick.
- R6: The frame-top pulse loads `mem_addr` and the row start with `start_addr`. Each `char_en` without `line_end` increments `mem_addr` modulo 2^16. Any other `line_end` returns `mem_addr` to the current row start.
- R7: A tick taken at `row_scan == max_scan` advances the row start by 2×`offset` when `dword_mode` = 0, or by 4×`offset` when `dword_mode` = 1. The sum is taken modulo 2^16, and `mem_addr` takes the new row start.
- R8: A pulse that moves `line_cnt` to `line_cmp` clears `mem_addr`, the row start and `row_scan` to 0 and restarts the doubling phase. This takes priority over the frame-top load.
- R9: `cursor_hit` is high exactly when all of these hold: `cur_off` = 0, `cur_start <= cur_end`, `cur_start <= row_scan <= cur_end`, and `mem_addr == cur_loc`.
- R10: `underline_hit` is high exactly when `row_scan == ul_row`.
- R11: While `rst_n` is low, `line_cnt`, `row_scan` and `mem_addr` are 0, and `vblank` and `vretrace` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | One-cycle end-of-scan-line pulse |
| char_en | input | 1 | Displayed character clock enable |
| vtotal | input | 10 | Last line number of the frame |
| vdisp_end | input | 10 | Last displayed line number |
| vret_start | input | 10 | Line at which retrace begins |
| vret_end | input | 4 | Low 4 bits of the line at which retrace ends |
| vblank_start | input | 10 | Line at which blanking begins |
| vblank_end | input | 8 | Low 8 bits of the line at which blanking ends |
| line_cmp | input | 10 | Split-screen line |
| max_scan | input | 5 | Scan lines per character row minus 1 |
| preset_row | input | 5 | Row scan value loaded at frame top |
| line_dbl | input | 1 | Halve the row-scan clock |
| start_addr | input | 16 | Refresh address at frame top |
| offset | input | 8 | Row pitch in words or double words |
| dword_mode | input | 1 | 1: pitch is 4×offset, 0: 2×offset |
| cur_start | input | 5 | First cursor row scan |
| cur_end | input | 5 | Last cursor row scan |
| cur_off | input | 1 | Suppress the cursor |
| cur_loc | input | 16 | Cursor memory address |
| ul_row | input | 5 | Underline row scan |
| line_cnt | output | 10 | Current scan line |
| vde | output | 1 | Vertical display enable |
| vblank | output | 1 | Vertical blanking |
| vretrace | output | 1 | Vertical retrace |
| row_scan | output | 5 | Row scan within the character row |
| mem_addr | output | 16 | Refresh memory address |
| cursor_hit | output | 1 | Cursor flag |
| underline_hit | output | 1 | Underline flag |

## Verification
The block is driven through whole frames under three settings. The first is a plain frame with word pitch and a zero preset, which exercises row advance, blanking, retrace and a visible cursor over two rows. The second scrolls with a nonzero preset, uses double-word pitch and line doubling, sets a start address that wraps past 2^16, places a split line mid-frame and programs an inverted cursor range. Together these separate preset reload from clear-to-zero at the row end and a 2× pitch from a 4× pitch. The third puts the split line on line 0 with a one-line character row and the cursor switched off, which tests line-compare priority over the frame-top load and the wrapping 4-bit retrace-end compare.

// File: rtl/rsag_pkg.sv
package rsag_pkg;
  typedef enum logic {PITCH_WORD = 1'b0, PITCH_DWORD = 1'b1} pitch_e;

  typedef enum logic [1:0] {
    ROW_HOLD,   // no line event
    ROW_SPLIT,  // line compare hit
    ROW_TOP,    // frame top reload
    ROW_LINE    // ordinary line end
  } row_evt_e;
endpackage

// File: rtl/rsag_line_ctr.sv
module rsag_line_ctr #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned REND_W = 4,
  parameter int unsigned BEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic [LINE_W-1:0] vtotal,
  input  logic [LINE_W-1:0] vdisp_end,
  input  logic [LINE_W-1:0] vret_start,
  input  logic [REND_W-1:0] vret_end,
  input  logic [LINE_W-1:0] vblank_start,
  input  logic [BEND_W-1:0] vblank_end,
  input  logic [LINE_W-1:0] line_cmp,
  output logic [LINE_W-1:0] line_cnt,
  output logic              vde,
  output logic              vblank,
  output logic              vretrace,
  output logic              frame_top,
  output logic              split_hit
);
  logic [LINE_W-1:0] nxt_line;

  always_comb begin
    nxt_line  = (line_cnt == vtotal) ? '0 : line_cnt + 1'b1;
    frame_top = line_end && (nxt_line == '0);
    split_hit = line_end && (nxt_line == line_cmp);
    vde       = (line_cnt <= vdisp_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      vretrace <= 1'b0;
      vblank   <= 1'b0;
    end else if (line_end) begin
      line_cnt <= nxt_line;
      // short-field compare ends each pulse
      if (vretrace) vretrace <= (nxt_line[REND_W-1:0] != vret_end);
      else          vretrace <= (nxt_line == vret_start);
      if (vblank)   vblank   <= (nxt_line[BEND_W-1:0] != vblank_end);
      else          vblank   <= (nxt_line == vblank_start);
    end
  end
endmodule

// File: rtl/rsag_row_addr.sv
module rsag_row_addr
  import rsag_pkg::*;
#(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              char_en,
  input  logic              frame_top,
  input  logic              split_hit,
  input  logic              line_dbl,
  input  logic [ROW_W-1:0]  max_scan,
  input  logic [ROW_W-1:0]  preset_row,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [OFS_W-1:0]  offset,
  input  logic              dword_mode,
  output logic [ROW_W-1:0]  row_scan,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int unsigned STEP_W = OFS_W + 2;

  logic [ADDR_W-1:0] row_base;
  logic [ADDR_W-1:0] next_base;
  logic [ADDR_W-1:0] pitch;
  logic [STEP_W-1:0] pitch_raw;
  logic              dbl_phase;
  logic              tick;
  pitch_e            pmode;
  row_evt_e          evt;

  always_comb begin
    pmode     = pitch_e'(dword_mode);
    pitch_raw = (pmode == PITCH_DWORD) ? {offset, 2'b00} : {1'b0, offset, 1'b0};
    pitch     = ADDR_W'(pitch_raw);
    next_base = row_base + pitch;
    tick      = !line_dbl || dbl_phase;
    if (split_hit)      evt = ROW_SPLIT;
    else if (frame_top) evt = ROW_TOP;
    else if (line_end)  evt = ROW_LINE;
    else                evt = ROW_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_scan  <= '0;
      row_base  <= '0;
      mem_addr  <= '0;
      dbl_phase <= 1'b0;
    end else begin
      unique case (evt)
        ROW_SPLIT: begin
          row_scan  <= '0;
          row_base  <= '0;
          mem_addr  <= '0;
          dbl_phase <= 1'b0;
        end
        ROW_TOP: begin
          row_scan  <= preset_row;
          row_base  <= start_addr;
          mem_addr  <= start_addr;
          dbl_phase <= 1'b0;
        end
        ROW_LINE: begin
          dbl_phase <= line_dbl && !dbl_phase;
          if (tick && (row_scan == max_scan)) begin
            row_scan <= '0;
            row_base <= next_base;
            mem_addr <= next_base;
          end else begin
            if (tick) row_scan <= row_scan + 1'b1;
            mem_addr <= row_base;
          end
        end
        default: begin
          if (char_en) mem_addr <= mem_addr + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsag_marker.sv
module rsag_marker #(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ROW_W-1:0]  row_scan,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ROW_W-1:0]  cur_start,
  input  logic [ROW_W-1:0]  cur_end,
  input  logic              cur_off,
  input  logic [ADDR_W-1:0] cur_loc,
  input  logic [ROW_W-1:0]  ul_row,
  output logic              cursor_hit,
  output logic              underline_hit
);
  logic in_rows;
  logic at_loc;

  always_comb begin
    in_rows       = (row_scan >= cur_start) && (row_scan <= cur_end);
    at_loc        = (mem_addr == cur_loc);
    cursor_hit    = !cur_off && (cur_start <= cur_end) && in_rows && at_loc;
    underline_hit = (row_scan == ul_row);
  end
endmodule

// File: rtl/row_scan_addr_gen.sv
module row_scan_addr_gen #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned REND_W = 4,
  parameter int unsigned BEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              char_en,
  input  logic [LINE_W-1:0] vtotal,
  input  logic [LINE_W-1:0] vdisp_end,
  input  logic [LINE_W-1:0] vret_start,
  input  logic [REND_W-1:0] vret_end,
  input  logic [LINE_W-1:0] vblank_start,
  input  logic [BEND_W-1:0] vblank_end,
  input  logic [LINE_W-1:0] line_cmp,
  input  logic [ROW_W-1:0]  max_scan,
  input  logic [ROW_W-1:0]  preset_row,
  input  logic              line_dbl,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [OFS_W-1:0]  offset,
  input  logic              dword_mode,
  input  logic [ROW_W-1:0]  cur_start,
  input  logic [ROW_W-1:0]  cur_end,
  input  logic              cur_off,
  input  logic [ADDR_W-1:0] cur_loc,
  input  logic [ROW_W-1:0]  ul_row,
  output logic [LINE_W-1:0] line_cnt,
  output logic              vde,
  output logic              vblank,
  output logic              vretrace,
  output logic [ROW_W-1:0]  row_scan,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cursor_hit,
  output logic              underline_hit
);
  logic frame_top;
  logic split_hit;

  rsag_line_ctr #(.LINE_W(LINE_W), .REND_W(REND_W), .BEND_W(BEND_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_end(line_end),
    .vtotal(vtotal), .vdisp_end(vdisp_end),
    .vret_start(vret_start), .vret_end(vret_end),
    .vblank_start(vblank_start), .vblank_end(vblank_end),
    .line_cmp(line_cmp), .line_cnt(line_cnt), .vde(vde),
    .vblank(vblank), .vretrace(vretrace),
    .frame_top(frame_top), .split_hit(split_hit)
  );

  rsag_row_addr #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_row (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .char_en(char_en),
    .frame_top(frame_top), .split_hit(split_hit), .line_dbl(line_dbl),
    .max_scan(max_scan), .preset_row(preset_row), .start_addr(start_addr),
    .offset(offset), .dword_mode(dword_mode),
    .row_scan(row_scan), .mem_addr(mem_addr)
  );

  rsag_marker #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_mark (
    .row_scan(row_scan), .mem_addr(mem_addr),
    .cur_start(cur_start), .cur_end(cur_end), .cur_off(cur_off),
    .cur_loc(cur_loc), .ul_row(ul_row),
    .cursor_hit(cursor_hit), .underline_hit(underline_hit)
  );
endmodule

// File: rtl/rsag_checker.sv
module rsag_checker #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REND_W = 4,
  parameter int unsigned BEND_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_end,
  input logic              char_en,
  input logic [LINE_W-1:0] vtotal,
  input logic [LINE_W-1:0] vret_start,
  input logic [REND_W-1:0] vret_end,
  input logic [LINE_W-1:0] vblank_start,
  input logic [BEND_W-1:0] vblank_end,
  input logic [LINE_W-1:0] line_cmp,
  input logic [ROW_W-1:0]  cur_start,
  input logic [ROW_W-1:0]  cur_end,
  input logic              cur_off,
  input logic [LINE_W-1:0] line_cnt,
  input logic              vblank,
  input logic              vretrace,
  input logic [ROW_W-1:0]  row_scan,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cursor_hit
);
  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && line_cnt == vtotal) |=> (line_cnt == '0));

  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line_cnt));

  assert_retrace_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vretrace) |-> (line_cnt == vret_start));

  assert_retrace_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vretrace) |-> (line_cnt[REND_W-1:0] == vret_end));

  assert_blank_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> (line_cnt == vblank_start));

  assert_blank_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> (line_cnt[BEND_W-1:0] == vblank_end));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && !line_end) |=> (mem_addr == $past(mem_addr) + 1'b1));

  assert_split_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && line_cnt != vtotal && (line_cnt + 1'b1) == line_cmp)
      |=> (mem_addr == '0 && row_scan == '0));

  assert_cursor_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_off |-> !cursor_hit);

  assert_cursor_inverted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_start > cur_end) |-> !cursor_hit);
endmodule

bind row_scan_addr_gen rsag_checker #(
  .LINE_W(LINE_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W),
  .REND_W(REND_W), .BEND_W(BEND_W)
) u_chk (.*);

// File: tb/row_scan_addr_gen_tb.sv
`timescale 1ns/1ps
module row_scan_addr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_end = 1'b0, char_en = 1'b0;
  logic [9:0] vtotal, vdisp_end, vret_start, vblank_start, line_cmp;
  logic [3:0] vret_end;
  logic [7:0] vblank_end, offset;
  logic [4:0] max_scan, preset_row, cur_start, cur_end, ul_row;
  logic line_dbl, dword_mode, cur_off;
  logic [15:0] start_addr, cur_loc;
  logic [9:0] line_cnt;
  logic vde, vblank, vretrace, cursor_hit, underline_hit;
  logic [4:0] row_scan;
  logic [15:0] mem_addr;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // reference state
  int m_line, m_row, m_addr, m_base, m_ph;
  bit m_vr, m_vb;

  always #2 clk = ~clk;

  row_scan_addr_gen u_dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_row = 0; m_addr = 0; m_base = 0; m_ph = 0; m_vr = 0; m_vb = 0;
    end else if (line_end) begin
      int nl;
      bit adv;
      nl = (m_line == int'(vtotal)) ? 0 : m_line + 1;
      if (m_vr) m_vr = ((nl % 16) != int'(vret_end)); else m_vr = (nl == int'(vret_start));
      if (m_vb) m_vb = ((nl % 256) != int'(vblank_end)); else m_vb = (nl == int'(vblank_start));
      if (nl == int'(line_cmp)) begin
        m_row = 0; m_base = 0; m_addr = 0; m_ph = 0;
      end else if (nl == 0) begin
        m_row = int'(preset_row); m_base = int'(start_addr); m_addr = m_base; m_ph = 0;
      end else begin
        adv = !line_dbl || (m_ph == 1);
        m_ph = line_dbl ? 1 - m_ph : 0;
        if (adv && m_row == int'(max_scan)) begin
          m_row = 0;
          m_base = (m_base + int'(offset) * (dword_mode ? 4 : 2)) % 65536;
          m_addr = m_base;
        end else begin
          if (adv) m_row = (m_row + 1) % 32;
          m_addr = m_base;
        end
      end
      m_line = nl;
    end else if (char_en) begin
      m_addr = (m_addr + 1) % 65536;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at line %0d", req, what, act, exp, m_line);
    end
  endtask

  // compare every clock, one time unit after the active edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      bit e_cur;
      e_cur = !cur_off && (cur_start <= cur_end) && (m_row >= int'(cur_start))
              && (m_row <= int'(cur_end)) && (m_addr == int'(cur_loc));
      if (!rst_n) begin
        chk("R11", "line_cnt", int'(line_cnt), 0);
        chk("R11", "row_scan", int'(row_scan), 0);
        chk("R11", "mem_addr", int'(mem_addr), 0);
        chk("R11", "vblank", int'(vblank), 0);
        chk("R11", "vretrace", int'(vretrace), 0);
      end else begin
        chk("R1", "line_cnt", int'(line_cnt), m_line);
        chk("R1", "vde", int'(vde), int'(m_line <= int'(vdisp_end)));
        chk("R2", "vretrace", int'(vretrace), int'(m_vr));
        chk("R3", "vblank", int'(vblank), int'(m_vb));
        chk(line_dbl ? "R5" : "R4", "row_scan", int'(row_scan), m_row);
        chk((line_cmp <= vtotal) ? "R8" : "R6/R7", "mem_addr", int'(mem_addr), m_addr);
        chk("R9", "cursor_hit", int'(cursor_hit), int'(e_cur));
        chk("R10", "underline_hit", int'(underline_hit), int'(m_row == int'(ul_row)));
      end
    end
  end

  task automatic run_lines(int nlines, int nchars);
    for (int l = 0; l < nlines; l++) begin
      for (int c = 0; c < nchars; c++) begin
        @(negedge clk);
        line_end = 1'b0;
        char_en = (m_line <= int'(vdisp_end));
      end
      @(negedge clk); char_en = 1'b0; line_end = 1'b1;
      @(negedge clk); line_end = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; line_end = 1'b0; char_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // setting 1: plain frame, word pitch, visible cursor (R1-R4, R6, R7, R9, R10)
    vtotal = 10'd39; vdisp_end = 10'd29; vblank_start = 10'd31; vblank_end = 8'd37;
    vret_start = 10'd33; vret_end = 4'd3; line_cmp = 10'd1023;
    max_scan = 5'd3; preset_row = 5'd0; line_dbl = 1'b0;
    start_addr = 16'h0100; offset = 8'd6; dword_mode = 1'b0;
    cur_start = 5'd1; cur_end = 5'd2; cur_off = 1'b0; cur_loc = 16'h010E; ul_row = 5'd3;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_lines(85, 10);

    // setting 2: scrolled, double-word, doubling, split, wrap, inverted cursor (R4, R5, R7, R8, R9)
    do_reset();
    preset_row = 5'd2; line_dbl = 1'b1; dword_mode = 1'b1; offset = 8'd5;
    start_addr = 16'hFFF8; line_cmp = 10'd17; cur_start = 5'd3; cur_end = 5'd1;
    cur_loc = 16'h0002; ul_row = 5'd0; max_scan = 5'd2;
    @(negedge clk); rst_n = 1'b1;
    run_lines(85, 9);

    // setting 3: split at line 0, one-line rows, cursor off, wrapping retrace end (R2, R8, R9)
    do_reset();
    line_dbl = 1'b0; dword_mode = 1'b0; max_scan = 5'd0; preset_row = 5'd0;
    line_cmp = 10'd0; cur_off = 1'b1; cur_start = 5'd0; cur_end = 5'd4; cur_loc = 16'h0003;
    vret_start = 10'd30; vret_end = 4'd1; vtotal = 10'd35;
    @(negedge clk); rst_n = 1'b1;
    run_lines(75, 8);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule